// File: doc/BRIEF.md
# Checkpoint Retry Unit

This block gives a pipelined core a way back to precise state without undoing each instruction. It holds the live architectural register file and a second bank of the same size that keeps a snapshot. A checkpoint strobe copies every live register into the snapshot in one cycle and records the address of the instruction that follows the checkpoint. Between checkpoints the execution units write the live file through an ordinary write port, in whatever order their results complete.

When an exception is reported, the unit records the faulting instruction's PC as a tag and spends one cycle restoring. During that cycle it presents the saved restart address to the fetch logic, and it copies the snapshot back into the live file on the closing edge. The unit then raises a sequential-mode flag that tells the pipeline to issue one instruction at a time without overlap. When the re-executed stream retires the instruction whose PC equals the tag, the state is precise. The unit leaves sequential mode and sends a one-cycle exception pulse, carrying that PC, to the handler. If an instruction faults while sequential mode is active, its state is already precise, so the unit passes it straight to the handler.

The reset state counts as the first checkpoint: every snapshot register is zero and the restart address is a parameter. A valid checkpoint therefore exists before the first instruction issues.

Top module: `ckpt_retry`

## Requirements
- R1: Reset state. Two cycles after the internal reset is released, `seq_mode`, `restart_valid` and `handler_exc` are 0 and every live register reads 0. An exception taken before any checkpoint restarts at `RESET_PC` with all registers at 0.
- R2: In normal mode, `wr_en` writes `wr_data` to register `wr_addr`. `rd_data` shows the new value for that address from the cycle after the edge, and all other registers keep their values. `rd_data` is combinational from `rd_addr`.
- R3: `ckpt_req` copies all live registers, as they stood before that clock edge, into the snapshot, and stores `ckpt_pc` as the restart address. A write on the same edge reaches only the live file.
- R4: `exc_valid` in normal mode records `exc_pc` as the fault tag. For exactly the next cycle, `restart_valid` is 1 and `restart_pc` carries the saved restart address. At the end of that cycle every live register equals its snapshot value.
- R5: During the restore cycle (`restart_valid` = 1), register writes, checkpoint requests and exceptions have no effect.
- R6: `seq_mode` is 1 from the restore cycle until `retire_valid` is seen with `retire_pc` equal to the fault tag. In the cycle after that edge, `seq_mode` is 0, `handler_exc` is 1 for one cycle and `handler_pc` equals the tag.
- R7: While `seq_mode` is 1, a retire whose PC differs from the tag, or a cycle with no retire, changes neither `seq_mode` nor `handler_exc`.
- R8: `exc_valid` during sequential mode ends it at once and does not restore. In the next cycle `handler_exc` is 1, `handler_pc` equals that `exc_pc`, and the live registers keep their values.
- R9: If `ckpt_req` and an accepted exception fall on the same edge, the checkpoint is dropped. The restore uses the earlier snapshot and the earlier restart address.
- R10: A checkpoint requested during sequential mode (outside the restore cycle) is taken, and a later rollback returns to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion is synchronised inside |
| wr_en | input | 1 | Register write strobe from the completion stage |
| wr_addr | input | 3 | Register index to write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register index to read |
| rd_data | output | 32 | Live register value at `rd_addr` |
| ckpt_req | input | 1 | Take a checkpoint on this edge |
| ckpt_pc | input | 32 | Address of the instruction after the checkpoint |
| exc_valid | input | 1 | An instruction has raised an exception |
| exc_pc | input | 32 | PC of the excepting instruction |
| retire_valid | input | 1 | An instruction retired in this cycle |
| retire_pc | input | 32 | PC of the retiring instruction |
| restart_valid | output | 1 | Restore cycle; fetch must restart at `restart_pc` |
| restart_pc | output | 32 | Saved restart address |
| seq_mode | output | 1 | Pipeline must issue without overlap |
| handler_exc | output | 1 | One-cycle precise exception to the handler |
| handler_pc | output | 32 | PC of the instruction handed to the handler |

## Verification
The hardest situation to reach is a rollback whose expected register contents differ from both the reset values and the current live values. This requires a checkpoint, then fresh writes, then an exception, all in that order. The stimulus sweeps every register with a distinct arithmetic pattern before each checkpoint and again after it. It places a write on the checkpoint edge itself, so the restored file can only match if the snapshot excluded that write. The restore cycle is hit with simultaneous write, checkpoint and exception strobes, and the sequence is repeated with the checkpoint taken inside sequential mode and with a checkpoint that collides with an exception.

// File: rtl/ckpt_retry_pkg.sv
package ckpt_retry_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_RESTORE = 2'd1,
    ST_SEQ     = 2'd2
  } crs_state_e;

endpackage

// File: rtl/ckpt_regbank.sv
module ckpt_regbank #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          snap_en,
  input  logic          restore_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] live_q [NREG];
  logic [DW-1:0] live_d [NREG];
  logic [DW-1:0] snap_q [NREG];
  logic [DW-1:0] snap_d [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic sel_w;
    assign sel_w = wr_en && (wr_addr == AW'(gi));

    always_comb begin
      live_d[gi] = live_q[gi];
      if (restore_en) begin
        live_d[gi] = snap_q[gi];
      end else if (sel_w) begin
        live_d[gi] = wr_data;
      end
    end

    always_comb begin
      snap_d[gi] = snap_q[gi];
      if (snap_en) begin
        snap_d[gi] = live_q[gi];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[gi] <= '0;
        snap_q[gi] <= '0;
      end else begin
        if (restore_en || sel_w) begin
          live_q[gi] <= live_d[gi];
        end
        if (snap_en) begin
          snap_q[gi] <= snap_d[gi];
        end
      end
    end

    AST_RESTORE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      restore_en |=> live_q[gi] == $past(snap_q[gi])); // R4

    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_en |=> snap_q[gi] == $past(snap_q[gi])); // R3
  end

  assign rd_data = live_q[rd_addr];

  AST_NO_SNAP_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> !snap_en); // R5

endmodule

// File: rtl/ckpt_tag_match.sv
module ckpt_tag_match #(
  parameter int PCW = 32
) (
  input  logic           retire_valid,
  input  logic [PCW-1:0] retire_pc,
  input  logic [PCW-1:0] fault_tag,
  input  logic           seq_active,
  output logic           tag_hit
);

  logic pc_equal;

  assign pc_equal = (retire_pc == fault_tag);
  assign tag_hit  = seq_active && retire_valid && pc_equal;

endmodule

// File: rtl/ckpt_seq_ctrl.sv
module ckpt_seq_ctrl
  import ckpt_retry_pkg::*;
#(
  parameter int             PCW      = 32,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ckpt_req,
  input  logic [PCW-1:0] ckpt_pc,
  input  logic           exc_valid,
  input  logic [PCW-1:0] exc_pc,
  input  logic           tag_hit,
  output logic [PCW-1:0] fault_tag,
  output logic           seq_active,
  output logic           wr_allow,
  output logic           snap_en,
  output logic           restore_en,
  output logic           restart_valid,
  output logic [PCW-1:0] restart_pc,
  output logic           handler_exc,
  output logic [PCW-1:0] handler_pc
);

  crs_state_e     state_q, state_d;
  logic [PCW-1:0] rpc_q, rpc_d;
  logic [PCW-1:0] tag_q, tag_d;
  logic           hdl_q, hdl_d;
  logic [PCW-1:0] hpc_q, hpc_d;
  logic           in_restore;
  logic           exc_take;

  assign in_restore = (state_q == ST_RESTORE);
  assign exc_take   = exc_valid && !in_restore;
  assign snap_en    = ckpt_req && !in_restore && !exc_take;
  assign restore_en = in_restore;
  assign wr_allow   = !in_restore;

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    hdl_d   = 1'b0;
    hpc_d   = hpc_q;
    rpc_d   = snap_en ? ckpt_pc : rpc_q;
    unique case (state_q)
      ST_RUN: begin
        if (exc_valid) begin
          state_d = ST_RESTORE;
          tag_d   = exc_pc;
        end
      end
      ST_RESTORE: begin
        state_d = ST_SEQ;
      end
      ST_SEQ: begin
        if (exc_valid) begin
          state_d = ST_RUN;
          hdl_d   = 1'b1;
          hpc_d   = exc_pc;
        end else if (tag_hit) begin
          state_d = ST_RUN;
          hdl_d   = 1'b1;
          hpc_d   = tag_q;
        end
      end
      default: begin
        state_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      rpc_q   <= RESET_PC;
      tag_q   <= '0;
      hdl_q   <= 1'b0;
      hpc_q   <= '0;
    end else begin
      state_q <= state_d;
      hdl_q   <= hdl_d;
      if (snap_en) begin
        rpc_q <= rpc_d;
      end
      if (state_q == ST_RUN && exc_valid) begin
        tag_q <= tag_d;
      end
      if (hdl_d) begin
        hpc_q <= hpc_d;
      end
    end
  end

  assign fault_tag     = tag_q;
  assign seq_active    = (state_q == ST_SEQ);
  assign restart_valid = in_restore;
  assign restart_pc    = rpc_q;
  assign handler_exc   = hdl_q;
  assign handler_pc    = hpc_q;

  AST_EXC_STARTS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && exc_valid) |=> restart_valid); // R4

  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> !restart_valid && seq_active); // R4

  AST_RESTORE_PC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |=> $stable(restart_pc)); // R5

  AST_HANDLER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    handler_exc |=> !handler_exc); // R6

  AST_HANDLER_FROM_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(handler_exc) |-> $past(seq_active)); // R6

  AST_SEQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !tag_hit && !exc_valid) |=> seq_active && !handler_exc); // R7

endmodule

// File: rtl/ckpt_retry.sv
module ckpt_retry #(
  parameter int             NREG     = 8,
  parameter int             DW       = 32,
  parameter int             PCW      = 32,
  parameter logic [PCW-1:0] RESET_PC = 32'h0000_0100,
  localparam int            AW       = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           ckpt_req,
  input  logic [PCW-1:0] ckpt_pc,
  input  logic           exc_valid,
  input  logic [PCW-1:0] exc_pc,
  input  logic           retire_valid,
  input  logic [PCW-1:0] retire_pc,
  output logic           restart_valid,
  output logic [PCW-1:0] restart_pc,
  output logic           seq_mode,
  output logic           handler_exc,
  output logic [PCW-1:0] handler_pc
);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           wr_allow;
  logic           snap_en;
  logic           restore_en;
  logic           seq_active;
  logic           tag_hit;
  logic [PCW-1:0] fault_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ckpt_seq_ctrl #(
    .PCW      (PCW),
    .RESET_PC (RESET_PC)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ckpt_req      (ckpt_req),
    .ckpt_pc       (ckpt_pc),
    .exc_valid     (exc_valid),
    .exc_pc        (exc_pc),
    .tag_hit       (tag_hit),
    .fault_tag     (fault_tag),
    .seq_active    (seq_active),
    .wr_allow      (wr_allow),
    .snap_en       (snap_en),
    .restore_en    (restore_en),
    .restart_valid (restart_valid),
    .restart_pc    (restart_pc),
    .handler_exc   (handler_exc),
    .handler_pc    (handler_pc)
  );

  ckpt_tag_match #(
    .PCW (PCW)
  ) u_match (
    .retire_valid (retire_valid),
    .retire_pc    (retire_pc),
    .fault_tag    (fault_tag),
    .seq_active   (seq_active),
    .tag_hit      (tag_hit)
  );

  ckpt_regbank #(
    .NREG (NREG),
    .DW   (DW)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en && wr_allow),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .snap_en    (snap_en),
    .restore_en (restore_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  assign seq_mode = seq_active || restart_valid;

  AST_SEQ_ENDS_WITH_HANDLER: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(seq_mode) |-> handler_exc); // R6

endmodule

// File: tb/tb_ckpt_retry.sv
module tb_ckpt_retry;

  localparam int          NREG  = 8;
  localparam logic [31:0] RSTPC = 32'h0000_0100;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        ckpt_req;
  logic [31:0] ckpt_pc;
  logic        exc_valid;
  logic [31:0] exc_pc;
  logic        retire_valid;
  logic [31:0] retire_pc;
  logic        restart_valid;
  logic [31:0] restart_pc;
  logic        seq_mode;
  logic        handler_exc;
  logic [31:0] handler_pc;

  int          n_tests;
  int          n_fail;
  logic [31:0] m_live [NREG];
  logic [31:0] m_snap [NREG];
  logic [31:0] m_rpc;

  ckpt_retry #(.RESET_PC(RSTPC)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ckpt_req(ckpt_req), .ckpt_pc(ckpt_pc),
    .exc_valid(exc_valid), .exc_pc(exc_pc),
    .retire_valid(retire_valid), .retire_pc(retire_pc),
    .restart_valid(restart_valid), .restart_pc(restart_pc),
    .seq_mode(seq_mode), .handler_exc(handler_exc), .handler_pc(handler_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_addr = 0; wr_data = 0; ckpt_req = 0; ckpt_pc = 0;
    exc_valid = 0; exc_pc = 0; retire_valid = 0; retire_pc = 0;
  endtask

  // called at a negedge with inputs already set; returns at the next negedge with inputs idle
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) begin
      rd_addr = 3'(i);
      #1;
      chk(rd_data == m_live[i], req, rd_data, m_live[i]);
    end
  endtask

  task automatic write_reg(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    tick();
    m_live[a] = d;
  endtask

  task automatic take_ckpt(input logic [31:0] pc);
    ckpt_req = 1; ckpt_pc = pc;
    tick();
    for (int i = 0; i < NREG; i++) m_snap[i] = m_live[i];
    m_rpc = pc;
  endtask

  // exception in run mode; checks restore cycle and restored file
  task automatic rollback(input logic [31:0] fpc, input string req);
    exc_valid = 1; exc_pc = fpc;
    tick();
    chk(restart_valid == 1'b1, req, 32'(restart_valid), 32'd1);
    chk(restart_pc == m_rpc, req, restart_pc, m_rpc);
    chk(seq_mode == 1'b1, req, 32'(seq_mode), 32'd1);
    // R5: strobes during the restore cycle have no effect
    wr_en = 1; wr_addr = 3'd5; wr_data = 32'hDEAD_BEEF;
    ckpt_req = 1; ckpt_pc = 32'hBAD0_0000;
    exc_valid = 1; exc_pc = 32'hBAD0_0004;
    tick();
    for (int i = 0; i < NREG; i++) m_live[i] = m_snap[i];
    chk(restart_valid == 1'b0, req, 32'(restart_valid), 32'd0);
    chk(seq_mode == 1'b1, "R5", 32'(seq_mode), 32'd1);
    chk(handler_exc == 1'b0, "R5", 32'(handler_exc), 32'd0);
    check_regs(req);
  endtask

  task automatic finish_seq(input logic [31:0] fpc);
    retire_valid = 1; retire_pc = fpc;
    tick();
    chk(seq_mode == 1'b0, "R6", 32'(seq_mode), 32'd0);
    chk(handler_exc == 1'b1, "R6", 32'(handler_exc), 32'd1);
    chk(handler_pc == fpc, "R6", handler_pc, fpc);
    tick();
    chk(handler_exc == 1'b0, "R6", 32'(handler_exc), 32'd0);
  endtask

  function automatic logic [31:0] pat(input int r, input int i);
    return (32'(r) * 32'h0101_0000) + (32'(i) * 32'h0000_1011) + 32'h0A00_0003;
  endfunction

  initial begin
    n_tests = 0; n_fail = 0;
    idle_inputs(); rd_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NREG; i++) begin m_live[i] = 0; m_snap[i] = 0; end
    m_rpc = RSTPC;

    // R1: reset state
    chk(seq_mode == 1'b0, "R1", 32'(seq_mode), 32'd0);
    chk(restart_valid == 1'b0, "R1", 32'(restart_valid), 32'd0);
    chk(handler_exc == 1'b0, "R1", 32'(handler_exc), 32'd0);
    check_regs("R1");

    // R1: rollback to the reset checkpoint
    write_reg(2, 32'h1234_5678);
    rollback(32'h0000_0140, "R1");
    finish_seq(32'h0000_0140);

    for (int r = 1; r <= 3; r++) begin
      // R2: full sweep of writes, each checked against the others
      for (int i = 0; i < NREG; i++) begin
        write_reg(i, pat(r, i));
        check_regs("R2");
      end
      // R3: checkpoint with a write on the same edge
      wr_en = 1; wr_addr = 3'(r); wr_data = pat(r + 10, r);
      take_ckpt(32'h0000_1000 * 32'(r));
      m_live[r] = pat(r + 10, r);
      check_regs("R3");
      for (int i = 0; i < NREG; i++) write_reg(i, pat(r + 20, i));
      rollback(32'h0000_2000 + 32'(r * 4), "R4");
      // R7: non-matching retires and idle cycles
      for (int k = 0; k < 3; k++) begin
        retire_valid = (k != 1); retire_pc = 32'h0000_3000 + 32'(k);
        tick();
        chk(seq_mode == 1'b1, "R7", 32'(seq_mode), 32'd1);
        chk(handler_exc == 1'b0, "R7", 32'(handler_exc), 32'd0);
      end
      if (r == 2) begin
        // R10: checkpoint in sequential mode, then roll back to it
        write_reg(4, 32'h4444_0002);
        take_ckpt(32'h0000_5000);
        finish_seq(32'h0000_2000 + 32'(r * 4));
        write_reg(4, 32'h9999_9999);
        rollback(32'h0000_6000, "R10");
        chk(m_live[4] == 32'h4444_0002, "R10", m_live[4], 32'h4444_0002);
        finish_seq(32'h0000_6000);
      end else begin
        finish_seq(32'h0000_2000 + 32'(r * 4));
      end
    end

    // R9: checkpoint colliding with exception is dropped
    for (int i = 0; i < NREG; i++) write_reg(i, pat(40, i));
    ckpt_req = 1; ckpt_pc = 32'h0000_7777;
    rollback(32'h0000_7000, "R9");
    finish_seq(32'h0000_7000);

    // R8: exception during sequential mode goes straight to the handler
    rollback(32'h0000_8000, "R8");
    write_reg(6, 32'h6666_0008);
    exc_valid = 1; exc_pc = 32'h0000_7FF0;
    tick();
    chk(seq_mode == 1'b0, "R8", 32'(seq_mode), 32'd0);
    chk(handler_exc == 1'b1, "R8", 32'(handler_exc), 32'd1);
    chk(handler_pc == 32'h0000_7FF0, "R8", handler_pc, 32'h0000_7FF0);
    chk(restart_valid == 1'b0, "R8", 32'(restart_valid), 32'd0);
    check_regs("R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule